// File: doc/BRIEF.md
# MAC Receive Power-Down Wake Controller

This block holds a MAC receive path in a power-down state. While it is in that state, every incoming frame is discarded. Software arms power-down through a small control register that also carries two wake-source enables: one for magic packets and one for wakeup frames. Upstream frame matchers report a recognised magic packet or wakeup pattern as a one-cycle detection pulse. When a pulse arrives for a source that is enabled while power-down is armed, the block leaves power-down by itself. It also raises a one-cycle wake pulse and sets a sticky flag that records which source woke it.

The receive side sees the frame stream as start, valid and end strobes. The block returns a per-beat drop qualifier for that stream. The drop decision is taken at each frame's start and held until that frame ends. As a result, a change of power-down state never cuts a frame in two. The sticky flags feed an interrupt status block. They read back through the same register and are cleared either by the read or by writing ones, depending on a parameter.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset, power-down (register bit 0), magic-packet enable (bit 1), wakeup-frame enable (bit 2), both received flags (bits 5 and 6), the wake pulse and the drop qualifier are all 0.
- R2: A register write loads bit 1 as the magic-packet enable and bit 2 as the wakeup-frame enable. It loads bit 0 as power-down when at least one of bits 1 and 2 in the same write is 1. All three bits read back at their positions on the cycle after the write.
- R3: A write with bit 0 set and both bits 1 and 2 clear leaves power-down at 0. Any write with both enables clear leaves power-down at 0.
- R4: While power-down is set at a frame's start beat, the drop qualifier is 1 on every valid beat of that frame. A frame started with power-down clear has the qualifier at 0 on every beat. The qualifier is 0 whenever valid is low.
- R5: A magic-packet pulse while power-down is set and the magic-packet enable is 1 clears power-down on the next cycle. On that same cycle it raises the wake pulse for exactly one cycle and sets the magic-received flag (bit 5).
- R6: A wakeup-frame pulse while power-down is set and the wakeup-frame enable is 1 clears power-down on the next cycle. On that same cycle it raises the wake pulse for exactly one cycle and sets the wakeup-received flag (bit 6).
- R7: A detection pulse whose own enable is 0 changes neither power-down, the flags nor the wake pulse.
- R8: A change of power-down in the middle of a frame does not alter that frame's drop qualifier. The new state applies from the next start beat.
- R9: Detection pulses while power-down is clear raise no wake pulse and set no flag.
- R10: The received flags stay set until a register read strobe. They are 0 on the cycle after the read.
- R11: When a qualified wake pulse coincides with a write that sets power-down, power-down ends at 0. The enables from the write still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | CFG_W | Register write data |
| cfg_rd_en | input | 1 | Register read strobe (clears flags in read-clear mode) |
| cfg_rd_data | output | CFG_W | Register read data |
| magic_det | input | 1 | One-cycle magic packet detection pulse |
| wuf_det | input | 1 | One-cycle wakeup frame detection pulse |
| rx_sof | input | 1 | Frame start strobe |
| rx_vld | input | 1 | Frame beat valid |
| rx_eof | input | 1 | Frame end strobe |
| rx_drop | output | 1 | Drop qualifier for the current valid beat |
| wake_evt | output | 1 | One-cycle wake pulse |
| magic_rcvd | output | 1 | Sticky magic-received flag |
| wuf_rcvd | output | 1 | Sticky wakeup-received flag |

## Verification
All eight register values are written from a cleared state. This separates the enable-gated arming of power-down from a plain load. Every combination of power-down, the two enables and the two detection pulses is then applied. The outcome is predicted arithmetically from the gating rule, which tells apart a pulse that is honoured, one masked by its enable, and one arriving outside power-down. Frame sequences clear power-down mid-frame and set it mid-frame, which shows that the drop decision is latched at the start beat. A wake that coincides with an arming write shows which of the two wins.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;
   localparam int PD_BIT  = 0;
   localparam int MPE_BIT = 1;
   localparam int WFE_BIT = 2;
   localparam int MPR_BIT = 5;
   localparam int WFR_BIT = 6;
   localparam int MIN_CFG_W = 7;

   typedef struct packed {
      logic wfe;
      logic mpe;
      logic pd;
   } pwr_cfg_t;
endpackage

// File: rtl/pwr_cfg_regs.sv
module pwr_cfg_regs
   import pwr_wake_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_en,
   input  pwr_cfg_t wr_cfg,
   input  logic     magic_det,
   input  logic     wuf_det,
   output pwr_cfg_t cfg,
   output logic     wake_mp,
   output logic     wake_wf
);
   logic wake_any;
   logic arm_ok;

   assign wake_mp  = cfg.pd & cfg.mpe & magic_det;
   assign wake_wf  = cfg.pd & cfg.wfe & wuf_det;
   assign wake_any = wake_mp | wake_wf;
   assign arm_ok   = wr_cfg.pd & (wr_cfg.mpe | wr_cfg.wfe);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr_en) begin
         cfg.mpe <= wr_cfg.mpe;
         cfg.wfe <= wr_cfg.wfe;
         cfg.pd  <= arm_ok & ~wake_any;
      end else if (wake_any) begin
         cfg.pd  <= 1'b0;
      end
   end

   // R3
   pd_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg.pd) |-> (cfg.mpe || cfg.wfe));
   // R5
   wake_clears_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_mp || wake_wf) |=> !cfg.pd);
endmodule

// File: rtl/pwr_wake_flags.sv
module pwr_wake_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic wake_mp,
   input  logic wake_wf,
   input  logic clr_mp,
   input  logic clr_wf,
   output logic mp_flag,
   output logic wf_flag,
   output logic wake_pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mp_flag    <= 1'b0;
         wf_flag    <= 1'b0;
         wake_pulse <= 1'b0;
      end else begin
         wake_pulse <= wake_mp | wake_wf;
         if (wake_mp)     mp_flag <= 1'b1;
         else if (clr_mp) mp_flag <= 1'b0;
         if (wake_wf)     wf_flag <= 1'b1;
         else if (clr_wf) wf_flag <= 1'b0;
      end
   end

   // R5
   mp_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_mp |=> (mp_flag && wake_pulse));
   // R6
   wf_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_wf |=> (wf_flag && wake_pulse));
   // R10
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mp_flag && !clr_mp) |=> mp_flag);
endmodule

// File: rtl/pwr_frame_gate.sv
module pwr_frame_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic pd,
   input  logic rx_sof,
   input  logic rx_vld,
   input  logic rx_eof,
   output logic rx_drop
);
   logic in_frame;
   logic drop_lat;
   logic start;

   assign start   = rx_vld & rx_sof;
   assign rx_drop = rx_vld & ((rx_sof | ~in_frame) ? pd : drop_lat);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         drop_lat <= 1'b0;
      end else if (rx_vld) begin
         if (rx_sof) drop_lat <= pd;
         in_frame <= ~rx_eof & (rx_sof | in_frame);
      end
   end

   // R8
   drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && !start) |=> $stable(drop_lat));
   // R4
   drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_vld |-> !rx_drop);
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
   import pwr_wake_pkg::*;
#(
   parameter int CFG_W        = 8,
   parameter bit FLAG_RD_CLEAR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr_en,
   input  logic [CFG_W-1:0] cfg_wr_data,
   input  logic             cfg_rd_en,
   output logic [CFG_W-1:0] cfg_rd_data,
   input  logic             magic_det,
   input  logic             wuf_det,
   input  logic             rx_sof,
   input  logic             rx_vld,
   input  logic             rx_eof,
   output logic             rx_drop,
   output logic             wake_evt,
   output logic             magic_rcvd,
   output logic             wuf_rcvd
);
   if (CFG_W < MIN_CFG_W) begin : g_bad_width
      $error("pwr_wake_ctrl: CFG_W too narrow for flag positions");
   end

   pwr_cfg_t wr_cfg, cfg;
   logic     wake_mp, wake_wf;
   logic     clr_mp, clr_wf;

   assign wr_cfg.pd  = cfg_wr_data[PD_BIT];
   assign wr_cfg.mpe = cfg_wr_data[MPE_BIT];
   assign wr_cfg.wfe = cfg_wr_data[WFE_BIT];

   if (FLAG_RD_CLEAR) begin : g_rd_clear
      assign clr_mp = cfg_rd_en;
      assign clr_wf = cfg_rd_en;
   end else begin : g_w1_clear
      assign clr_mp = cfg_wr_en & cfg_wr_data[MPR_BIT];
      assign clr_wf = cfg_wr_en & cfg_wr_data[WFR_BIT];
   end

   logic unused_bits;
   assign unused_bits = ^{cfg_wr_data, cfg_rd_en};

   pwr_cfg_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_cfg(wr_cfg),
      .magic_det(magic_det), .wuf_det(wuf_det), .cfg(cfg),
      .wake_mp(wake_mp), .wake_wf(wake_wf)
   );

   pwr_wake_flags u_flags (
      .clk(clk), .rst_n(rst_n), .wake_mp(wake_mp), .wake_wf(wake_wf),
      .clr_mp(clr_mp), .clr_wf(clr_wf), .mp_flag(magic_rcvd),
      .wf_flag(wuf_rcvd), .wake_pulse(wake_evt)
   );

   pwr_frame_gate u_gate (
      .clk(clk), .rst_n(rst_n), .pd(cfg.pd), .rx_sof(rx_sof),
      .rx_vld(rx_vld), .rx_eof(rx_eof), .rx_drop(rx_drop)
   );

   always_comb begin
      cfg_rd_data          = '0;
      cfg_rd_data[PD_BIT]  = cfg.pd;
      cfg_rd_data[MPE_BIT] = cfg.mpe;
      cfg_rd_data[WFE_BIT] = cfg.wfe;
      cfg_rd_data[MPR_BIT] = magic_rcvd;
      cfg_rd_data[WFR_BIT] = wuf_rcvd;
   end

   // R9
   wake_only_in_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_evt |-> $past(cfg.pd));
   // R5
   wake_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_evt |=> !wake_evt);
endmodule

// File: tb/tb_pwr_wake_ctrl.sv
module tb_pwr_wake_ctrl;
   localparam int W = 8;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr_en = 0, cfg_rd_en = 0;
   logic [W-1:0] cfg_wr_data = '0;
   logic [W-1:0] cfg_rd_data;
   logic magic_det = 0, wuf_det = 0, rx_sof = 0, rx_vld = 0, rx_eof = 0;
   logic rx_drop, wake_evt, magic_rcvd, wuf_rcvd;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pwr_wake_ctrl #(.CFG_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
      .cfg_rd_en(cfg_rd_en), .cfg_rd_data(cfg_rd_data), .magic_det(magic_det),
      .wuf_det(wuf_det), .rx_sof(rx_sof), .rx_vld(rx_vld), .rx_eof(rx_eof),
      .rx_drop(rx_drop), .wake_evt(wake_evt), .magic_rcvd(magic_rcvd),
      .wuf_rcvd(wuf_rcvd)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int v);
      @(negedge clk); cfg_wr_en = 1; cfg_wr_data = W'(v);
      @(negedge clk); cfg_wr_en = 0; cfg_wr_data = '0;
   endtask

   task automatic rdclr();
      @(negedge clk); cfg_rd_en = 1;
      @(negedge clk); cfg_rd_en = 0;
   endtask

   task automatic beat(input bit s, input bit e, input bit mp, input int exp, input string req);
      @(negedge clk); rx_vld = 1; rx_sof = s; rx_eof = e; magic_det = mp;
      #5 chk(req, int'(rx_drop), exp);
   endtask

   task automatic idle();
      @(negedge clk); rx_vld = 0; rx_sof = 0; rx_eof = 0; magic_det = 0;
      #5 chk("R4 idle", int'(rx_drop), 0);
   endtask

   initial begin
      #(20 * 150000);
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1
      chk("R1 regs", int'(cfg_rd_data), 0);
      chk("R1 outs", int'({wake_evt, rx_drop, magic_rcvd, wuf_rcvd}), 0);

      // R2 / R3: every write value from a cleared state
      for (int v = 0; v < 8; v++) begin
         int exp;
         wr(0); wr(v);
         exp = (v & 6) | ((v & 1) && (v & 6) ? 1 : 0);
         chk("R2/R3 write", int'(cfg_rd_data[2:0]), exp);
      end
      wr(3); wr(1);
      chk("R3 clear enables", int'(cfg_rd_data[2:0]), 0);

      // R5 R6 R7 R9: every pd/enable/pulse combination
      for (int c = 0; c < 8; c++) begin
         for (int p = 0; p < 4; p++) begin
            bit pd, mpe, wfe, emp, ewf;
            mpe = c[1]; wfe = c[2];
            pd = c[0] && (mpe || wfe);
            wr(0); rdclr(); wr(c);
            @(negedge clk); magic_det = p[0]; wuf_det = p[1];
            @(negedge clk); magic_det = 0; wuf_det = 0;
            emp = pd && mpe && p[0];
            ewf = pd && wfe && p[1];
            chk("R5/R6/R7/R9 pd", int'(cfg_rd_data[0]), int'(pd && !(emp || ewf)));
            chk("R5/R6/R7/R9 pulse", int'(wake_evt), int'(emp || ewf));
            chk("R5/R7/R9 magic flag", int'(cfg_rd_data[5]), int'(emp));
            chk("R6/R7/R9 wake flag", int'(cfg_rd_data[6]), int'(ewf));
            @(negedge clk);
            chk("R5/R6 pulse one cycle", int'(wake_evt), 0);
         end
      end

      // R10: sticky until read strobe
      wr(0); rdclr(); wr(7);
      @(negedge clk); wuf_det = 1;
      @(negedge clk); wuf_det = 0;
      repeat (4) @(negedge clk);
      chk("R10 sticky", int'({magic_rcvd, wuf_rcvd}), 1);
      rdclr();
      chk("R10 cleared", int'(cfg_rd_data[6:5]), 0);

      // R11: wake coincides with arming write
      wr(0); wr(3);
      @(negedge clk); cfg_wr_en = 1; cfg_wr_data = 8'h07; magic_det = 1;
      @(negedge clk); cfg_wr_en = 0; cfg_wr_data = '0; magic_det = 0;
      chk("R11 wake wins", int'(cfg_rd_data[2:0]), 6);
      rdclr();

      // R4 / R8: pd cleared mid-frame
      wr(3);
      beat(1, 0, 0, 1, "R4 sof dropped");
      beat(0, 0, 1, 1, "R8 wake beat");
      beat(0, 0, 0, 1, "R8 held after wake");
      beat(0, 1, 0, 1, "R8 eof dropped");
      beat(1, 0, 0, 0, "R8 next frame fwd");
      beat(0, 1, 0, 0, "R4 fwd eof");
      idle();
      // R8: pd set mid-frame
      beat(1, 0, 0, 0, "R8 sof fwd");
      idle();
      wr(3);
      beat(0, 0, 0, 0, "R8 fwd held");
      beat(0, 1, 0, 0, "R8 fwd eof");
      beat(1, 1, 0, 1, "R4 single beat dropped");
      idle();
      rdclr();

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule